// File: doc/BRIEF.md
# Key-Sequenced 64-bit Watchdog Timer

This block is a watchdog built on a 64-bit up-counter and a 64-bit period register. Each of them is split into two 32-bit words on a simple register port. Software first loads the period and selects watchdog operation in the global control word. It then arms the timer by writing two 16-bit keys in order to the watchdog control word. From the first accepted key onward, the block is locked: the counter, the period and both control words ignore writes, and the timer can never be switched off again until a device reset.

While it is running, the counter advances on every cycle in which `count_tick` is high. Software keeps the system alive by writing the same pair of keys again, which restarts the count from zero. If the counter reaches the period first, the block raises `rst_req` for one cycle, sets a sticky timeout flag and starts counting again from zero. Reads are combinational and return the current contents of the addressed register.

Top module: `keyed_wdog64`

## Requirements
- R1: After reset, the counter, period, timer control, global control and watchdog control words all read 0, `rst_req` is low, and the identity word at byte offset 0x00 reads the `ID_VALUE` parameter (default 0x5744_0064).
- R2: While disarmed, writes to counter low/high (0x10/0x14), period low/high (0x18/0x1C), timer control (0x20, run-mode field at bits 7:6) and global control (0x24) are stored and read back unchanged.
- R3: A watchdog control write (0x28) with key 0xA5C6 in bits 31:16 and bit 14 set moves the block to pre-active only when global control has bits 0 and 1 set and bits 3:2 equal to 2. Otherwise the block stays disarmed and its configuration stays writable.
- R4: From pre-active, a watchdog control write with key 0xDA7E and bit 14 set makes the watchdog active and clears the counter. From pre-active onward, writes to the counter, period, timer control and global control words have no effect.
- R5: The counter advances by one on each cycle with `count_tick` high only while active. It holds in every other state.
- R6: An enabled tick that finds the counter equal to the 64-bit period raises `rst_req` for exactly the following cycle, clears the counter and sets the flag at bit 15 of the watchdog control word.
- R7: While active, a write of key 0xA5C6 followed directly (as the next watchdog control write) by key 0xDA7E clears the counter. The first key alone does not, and any other key between the two cancels the pair.
- R8: Once armed, no write disables the watchdog: bit 14 of the watchdog control word keeps reading 1 and counting continues.
- R9: Writing 1 to bit 15 of the watchdog control word clears the timeout flag in any state.
- R10: The watchdog control word reads back as {last written key, flag, enable, 14 zero bits}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous device reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| count_tick | input | 1 | Counter enable for this cycle |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The assertions watch several properties on every cycle. The configuration stays frozen once the block is locked, the block never falls back to disarmed, arming is refused without watchdog mode, and a reset request comes only from the active state, with the counter cleared and the flag set. A service restart always leaves the counter at zero. What the assertions cannot show is the meaning of the key pair in time: that a lone first key or an interrupted pair leaves the count untouched, that a timeout lands on exactly the tick where the counter equals the period, and that read-back formats and the write-one-to-clear flag behave. The directed scenarios of the bench cover these.

// File: rtl/keyed_wdog64_pkg.sv
package keyed_wdog64_pkg;

  localparam int AW = 8;

  localparam logic [AW-1:0] OFS_IDENT  = 8'h00;
  localparam logic [AW-1:0] OFS_EMU    = 8'h04;
  localparam logic [AW-1:0] OFS_CNT_LO = 8'h10;
  localparam logic [AW-1:0] OFS_CNT_HI = 8'h14;
  localparam logic [AW-1:0] OFS_PRD_LO = 8'h18;
  localparam logic [AW-1:0] OFS_PRD_HI = 8'h1C;
  localparam logic [AW-1:0] OFS_RUNCTL = 8'h20;
  localparam logic [AW-1:0] OFS_GLBCTL = 8'h24;
  localparam logic [AW-1:0] OFS_WDCTL  = 8'h28;

  localparam logic [15:0] KEY_OPEN  = 16'hA5C6;
  localparam logic [15:0] KEY_CLOSE = 16'hDA7E;

  localparam logic [1:0] GLB_MODE_WDOG = 2'd2;

  typedef enum logic [1:0] {
    WD_OFF = 2'd0,
    WD_PRE = 2'd1,
    WD_RUN = 2'd2
  } wd_state_e;

  // Global control permits arming: both halves out of reset, watchdog mode.
  function automatic logic glb_allows_arm(input logic [3:0] glb);
    return glb[0] && glb[1] && (glb[3:2] == GLB_MODE_WDOG);
  endfunction

  // Key comparison helpers.
  function automatic logic is_open_key(input logic [15:0] k);
    return k == KEY_OPEN;
  endfunction

  function automatic logic is_close_key(input logic [15:0] k);
    return k == KEY_CLOSE;
  endfunction

endpackage

// File: rtl/keyed_wdog64_cfg.sv
module keyed_wdog64_cfg
  import keyed_wdog64_pkg::*;
#(
  parameter int DW = 32,
  parameter int NH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  input  logic               locked,
  output logic [NH*DW-1:0]   prd,
  output logic [DW-1:0]      runctl,
  output logic [DW-1:0]      glbctl,
  output logic [DW-1:0]      emuctl
);

  logic [NH-1:0] prd_wr;
  logic          run_wr;
  logic          glb_wr;
  logic          emu_wr;

  // Period word strobes; halves follow each other at 4-byte steps.
  generate
    for (genvar h = 0; h < NH; h++) begin : g_prd_dec
      assign prd_wr[h] = wr_en && !locked &&
                         (addr == OFS_PRD_LO + AW'(4 * h));
    end
  endgenerate

  assign run_wr = wr_en && !locked && (addr == OFS_RUNCTL);
  assign glb_wr = wr_en && !locked && (addr == OFS_GLBCTL);
  assign emu_wr = wr_en && (addr == OFS_EMU);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd    <= '0;
      runctl <= '0;
      glbctl <= '0;
      emuctl <= '0;
    end else begin
      for (int h = 0; h < NH; h++) begin
        if (prd_wr[h]) prd[h*DW +: DW] <= wdata;
      end
      if (run_wr) runctl <= wdata;
      if (glb_wr) glbctl <= wdata;
      if (emu_wr) emuctl <= wdata;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(prd) && $stable(runctl) && $stable(glbctl))); // R4

endmodule

// File: rtl/keyed_wdog64_count.sv
module keyed_wdog64_count #(
  parameter int DW = 32,
  parameter int NH = 2,
  localparam int CW = NH * DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NH-1:0]   sw_wr,
  input  logic [DW-1:0]   wdata,
  input  logic            run,
  input  logic            tick,
  input  logic            restart,
  input  logic [CW-1:0]   prd,
  output logic [CW-1:0]   cnt,
  output logic            hit,
  output logic            expire
);

  // Timeout event: an enabled tick that finds the count at the period.
  assign hit = run && tick && !restart && (cnt == prd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= hit;
      if (restart) begin
        cnt <= '0;
      end else if (run && tick) begin
        cnt <= hit ? '0 : cnt + CW'(1);
      end else begin
        for (int h = 0; h < NH; h++) begin
          if (sw_wr[h]) cnt[h*DW +: DW] <= wdata;
        end
      end
    end
  end

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0)); // R7

  AST_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (cnt == '0)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart && (sw_wr == '0)) |=> $stable(cnt)); // R5

  AST_SINGLE_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && (prd != '0)) |=> !expire); // R6

endmodule

// File: rtl/keyed_wdog64_keyfsm.sv
module keyed_wdog64_keyfsm
  import keyed_wdog64_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [15:0] key_in,
  input  logic       en_in,
  input  logic       flag_clr_in,
  input  logic       arm_ok,
  input  logic       hit,
  output wd_state_e  state,
  output logic       locked,
  output logic       restart,
  output logic       wd_en,
  output logic       wd_flag,
  output logic [15:0] key_q
);

  logic      half_seen;
  wd_state_e state_nx;
  logic      arm_req;
  logic      go_req;
  logic      svc_req;

  assign arm_req = key_wr && en_in && is_open_key(key_in) && arm_ok;
  assign go_req  = key_wr && en_in && is_close_key(key_in);
  assign svc_req = key_wr && half_seen && is_close_key(key_in);

  always_comb begin
    state_nx = state;
    unique case (state)
      WD_OFF:  if (arm_req) state_nx = WD_PRE;
      WD_PRE:  if (go_req)  state_nx = WD_RUN;
      default: state_nx = WD_RUN;
    endcase
  end

  assign restart = ((state == WD_PRE) && go_req) ||
                   ((state == WD_RUN) && svc_req);
  assign locked  = (state != WD_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= WD_OFF;
      half_seen <= 1'b0;
      wd_en     <= 1'b0;
      wd_flag   <= 1'b0;
      key_q     <= '0;
    end else begin
      state <= state_nx;
      if (key_wr) key_q <= key_in;
      if (state == WD_OFF) begin
        if (key_wr) wd_en <= en_in;
        if (arm_req) wd_en <= 1'b1;
      end
      if (state == WD_RUN && key_wr) begin
        half_seen <= is_open_key(key_in);
      end else if (state != WD_RUN) begin
        half_seen <= 1'b0;
      end
      if (hit)              wd_flag <= 1'b1;
      else if (flag_clr_in) wd_flag <= 1'b0;
    end
  end

  AST_NO_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (state != WD_OFF) |=> (state != WD_OFF)); // R8

  AST_ENABLE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (state != WD_OFF) |-> wd_en); // R8

  AST_ARM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == WD_OFF) && !arm_ok) |=> (state == WD_OFF)); // R3

  AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> wd_flag); // R6

endmodule

// File: rtl/keyed_wdog64.sv
module keyed_wdog64
  import keyed_wdog64_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [31:0] ID_VALUE = 32'h5744_0064
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          count_tick,
  output logic          rst_req
);

  localparam int NH = 2;
  localparam int CW = NH * DW;

  logic [CW-1:0] prd;
  logic [CW-1:0] cnt;
  logic [DW-1:0] runctl;
  logic [DW-1:0] glbctl;
  logic [DW-1:0] emuctl;
  logic [NH-1:0] cnt_wr;
  wd_state_e     state;
  logic          locked;
  logic          restart;
  logic          hit;
  logic          wd_en;
  logic          wd_flag;
  logic [15:0]   key_q;
  logic          key_wr;

  generate
    for (genvar h = 0; h < NH; h++) begin : g_cnt_dec
      assign cnt_wr[h] = wr_en && !locked &&
                         (addr == OFS_CNT_LO + AW'(4 * h));
    end
  endgenerate

  assign key_wr = wr_en && (addr == OFS_WDCTL);

  keyed_wdog64_cfg #(.DW(DW), .NH(NH)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .locked (locked),
    .prd    (prd),
    .runctl (runctl),
    .glbctl (glbctl),
    .emuctl (emuctl)
  );

  keyed_wdog64_keyfsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_wr      (key_wr),
    .key_in      (wdata[31:16]),
    .en_in       (wdata[14]),
    .flag_clr_in (key_wr && wdata[15]),
    .arm_ok      (glb_allows_arm(glbctl[3:0])),
    .hit         (hit),
    .state       (state),
    .locked      (locked),
    .restart     (restart),
    .wd_en       (wd_en),
    .wd_flag     (wd_flag),
    .key_q       (key_q)
  );

  keyed_wdog64_count #(.DW(DW), .NH(NH)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_wr   (cnt_wr),
    .wdata   (wdata),
    .run     (state == WD_RUN),
    .tick    (count_tick),
    .restart (restart),
    .prd     (prd),
    .cnt     (cnt),
    .hit     (hit),
    .expire  (rst_req)
  );

  always_comb begin
    unique case (addr)
      OFS_IDENT:  rdata = ID_VALUE;
      OFS_EMU:    rdata = emuctl;
      OFS_CNT_LO: rdata = cnt[DW-1:0];
      OFS_CNT_HI: rdata = cnt[CW-1:DW];
      OFS_PRD_LO: rdata = prd[DW-1:0];
      OFS_PRD_HI: rdata = prd[CW-1:DW];
      OFS_RUNCTL: rdata = runctl;
      OFS_GLBCTL: rdata = glbctl;
      OFS_WDCTL:  rdata = {key_q, wd_flag, wd_en, 14'd0};
      default:    rdata = '0;
    endcase
  end

  AST_REQ_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (state == WD_RUN && wd_flag)); // R6

endmodule

// File: tb/keyed_wdog64_tb.sv
`timescale 1ns/1ps
module keyed_wdog64_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        count_tick = 1'b0;
  logic        rst_req;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  keyed_wdog64 u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .count_tick (count_tick),
    .rst_req    (rst_req)
  );

  localparam logic [31:0] OPEN_EN  = 32'hA5C6_4000;
  localparam logic [31:0] CLOSE_EN = 32'hDA7E_4000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    count_tick = 1'b1;
    repeat (n) @(negedge clk);
    count_tick = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 ident", 8'h00, 32'h5744_0064);
    rd_chk("R1 cnt", 8'h10, 32'h0);
    rd_chk("R1 prd", 8'h1C, 32'h0);
    rd_chk("R1 wdctl", 8'h28, 32'h0);
    chk("R1 rst_req", {31'd0, rst_req}, 32'h0);
  endtask

  task automatic t_config;
    wr(8'h18, 32'd5);
    wr(8'h1C, 32'h11);
    wr(8'h20, 32'h80);
    wr(8'h24, 32'h3);
    wr(8'h10, 32'h77);
    rd_chk("R2 prd lo", 8'h18, 32'd5);
    rd_chk("R2 prd hi", 8'h1C, 32'h11);
    rd_chk("R2 runctl", 8'h20, 32'h80);
    rd_chk("R2 glbctl", 8'h24, 32'h3);
    rd_chk("R2 cnt lo", 8'h10, 32'h77);
  endtask

  task automatic t_arm_blocked;
    wr(8'h28, OPEN_EN);
    wr(8'h1C, 32'h0);
    rd_chk("R3 still writable", 8'h1C, 32'h0);
  endtask

  task automatic t_arm;
    wr(8'h24, 32'hB);
    wr(8'h28, OPEN_EN);
    wr(8'h18, 32'd9);
    rd_chk("R4 period locked", 8'h18, 32'd5);
    wr(8'h24, 32'h0);
    rd_chk("R4 glbctl locked", 8'h24, 32'hB);
    wr(8'h10, 32'h3);
    rd_chk("R4 cnt locked", 8'h10, 32'h77);
    ticks(2);
    rd_chk("R5 no count pre-active", 8'h10, 32'h77);
    wr(8'h28, CLOSE_EN);
    rd_chk("R4 active clears cnt", 8'h10, 32'h0);
  endtask

  task automatic t_count;
    ticks(3);
    rd_chk("R5 count lo", 8'h10, 32'd3);
    rd_chk("R5 count hi", 8'h14, 32'd0);
  endtask

  task automatic t_timeout;
    ticks(2);
    rd_chk("R6 at period", 8'h10, 32'd5);
    chk("R6 no req yet", {31'd0, rst_req}, 32'h0);
    ticks(1);
    chk("R6 req raised", {31'd0, rst_req}, 32'h1);
    rd_chk("R6 cnt cleared", 8'h10, 32'd0);
    rd_chk("R10 wdctl after timeout", 8'h28, 32'hDA7E_C000);
    @(negedge clk);
    chk("R6 req one cycle", {31'd0, rst_req}, 32'h0);
  endtask

  task automatic t_service;
    ticks(4);
    wr(8'h28, 32'hA5C6_0000);
    rd_chk("R7 first key alone", 8'h10, 32'd4);
    wr(8'h28, 32'h1234_0000);
    wr(8'h28, 32'hDA7E_0000);
    rd_chk("R7 broken pair", 8'h10, 32'd4);
    wr(8'h28, 32'hA5C6_0000);
    wr(8'h28, 32'hDA7E_0000);
    rd_chk("R7 pair restarts", 8'h10, 32'd0);
  endtask

  task automatic t_nodisable;
    wr(8'h28, 32'h0000_0000);
    rd_chk("R8 enable stays", 8'h28, 32'h0000_C000);
    ticks(2);
    rd_chk("R8 still counting", 8'h10, 32'd2);
  endtask

  task automatic t_flag;
    wr(8'h28, 32'h0000_8000);
    rd_chk("R9 flag cleared", 8'h28, 32'h0000_4000);
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_arm_blocked();
    t_arm();
    t_count();
    t_timeout();
    t_service();
    t_nodisable();
    t_flag();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule